// File: doc/BRIEF.md
# Flash Bad-Block Spare Remapper

This block sits between a flash management layer and the flash array. It turns logical block numbers into physical block numbers. A small pool of physical blocks above the logical range is held back as spares, and no spare is handed out while no failure has been reported. When the host reports a logical block as failed, the block takes the lowest unused spare. It then asks the array to copy the old contents into that spare and waits for the array to confirm the copy. The new mapping takes effect only after that confirmation.

Each request carries an operation and a logical block number. The block answers one cycle later with a one-cycle response that holds either a physical block number or an error flag. The flash array is seen only through a copy-request/copy-done handshake.

When the last spare's copy completes, the block enters a write lock that only reset clears. In that lock every program request and every failure report is refused, while reads still translate normally so that the data can be backed up.

Top module: `fbb_remapper`

## Requirements
- R1: After reset, `rsp_valid`, `copy_req`, `busy` and `wlock` are 0, and no logical block is remapped.
- R2: A request sampled at a clock edge produces `rsp_valid` for exactly the following cycle. For a logical block that has not been remapped, a read (op 2'b00) or an accepted program (op 2'b01) returns `rsp_pblk` equal to the logical number with `rsp_err` 0.
- R3: Spare k (k counted from 0) is physical block NUM_LOG+k. An accepted failure report (op 2'b10) hands out spares in ascending order and returns the newly assigned spare's physical number with `rsp_err` 0.
- R4: An accepted failure report raises `copy_req` and `busy` in the response cycle. `copy_src` holds the block's current physical number and `copy_dst` holds the new spare. These are held until `copy_done` is sampled high.
- R5: The new mapping takes effect only at the edge where `copy_done` is sampled. A request sampled at that same edge, or earlier, still receives the old physical number.
- R6: A failure report sampled while a copy is in progress returns `rsp_err` 1 and starts no copy.
- R7: Once every spare's copy has completed, `wlock` is 1 until reset. A program or failure report sampled while `wlock` is 1 returns `rsp_err` 1, `rsp_pblk` 0, and starts no copy.
- R8: While `wlock` is 1, reads still return the current mapping, remapped or not, with `rsp_err` 0.
- R9: The reserved op 2'b11, or a logical number at or above NUM_LOG, returns `rsp_err` 1 with `rsp_pblk` 0.
- R10: A failure report for a block that is already remapped uses that block's current spare as `copy_src` and assigns the next spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 read, 01 program, 10 failure report, 11 reserved |
| req_lblk | input | LW | Logical block number |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request refused |
| rsp_pblk | output | PW | Physical block number (0 on error) |
| busy | output | 1 | Copy in progress; failure reports are refused |
| copy_req | output | 1 | Copy request to the flash array |
| copy_src | output | PW | Physical block to copy from |
| copy_dst | output | PW | Spare block to copy into |
| copy_done | input | 1 | Array reports the copy finished |
| wlock | output | 1 | Permanent write lock |

## Verification
Two things can meet in one cycle: the commit of a remap when `copy_done` is sampled, and a host request that looks up the same logical block. The bench drives `copy_done` and a read of the block being remapped in the same cycle. It expects the old physical number in that response and the spare in the next one. The same kind of collision is also forced at the last spare: a program is sampled together with the final `copy_done` and must still be accepted, and only the program after it must be refused.

// File: rtl/fbb_remap_pkg.sv
package fbb_remap_pkg;
    typedef enum logic [1:0] {
        OP_READ = 2'b00,
        OP_PROG = 2'b01,
        OP_FAIL = 2'b10,
        OP_RSVD = 2'b11
    } op_e;
endpackage

// File: rtl/fbb_remap_table.sv
// Per-logical-block remap entries: a remapped flag and the spare index in use.
module fbb_remap_table #(
    parameter int NUM_LOG = 32,
    parameter int LW      = 5,
    parameter int SW      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] look_idx,
    output logic          look_hit,
    output logic [SW-1:0] look_sidx,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_idx,
    input  logic [SW-1:0] wr_sidx
);
    logic          hit_q  [NUM_LOG];
    logic [SW-1:0] sidx_q [NUM_LOG];

    for (genvar g = 0; g < NUM_LOG; g++) begin : g_entry
        logic          hit_d;
        logic [SW-1:0] sidx_d;
        logic          sel;

        assign sel = wr_en && (wr_idx == LW'(g));

        always_comb begin
            hit_d  = hit_q[g];
            sidx_d = sidx_q[g];
            if (sel) begin
                hit_d  = 1'b1;
                sidx_d = wr_sidx;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q[g]  <= 1'b0;
                sidx_q[g] <= '0;
            end else begin
                hit_q[g]  <= hit_d;
                sidx_q[g] <= sidx_d;
            end
        end
    end

    always_comb begin
        look_hit  = 1'b0;
        look_sidx = '0;
        for (int i = 0; i < NUM_LOG; i++) begin
            if (look_idx == LW'(i)) begin
                look_hit  = hit_q[i];
                look_sidx = sidx_q[i];
            end
        end
    end
endmodule

// File: rtl/fbb_spare_alloc.sv
// Ascending spare allocator; exhausted once every spare is committed.
module fbb_spare_alloc #(
    parameter int NUM_SPARE = 4,
    parameter int SW        = 2,
    parameter int CW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    output logic [SW-1:0] next_sidx,
    output logic          exhausted
);
    localparam logic [CW-1:0] LIMIT = CW'(NUM_SPARE);

    logic [CW-1:0] used_d, used_q;

    always_comb begin
        used_d = used_q;
        if (take && (used_q != LIMIT)) used_d = used_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

    assign next_sidx = used_q[SW-1:0];
    assign exhausted = (used_q == LIMIT);
endmodule

// File: rtl/fbb_remapper.sv
module fbb_remapper #(
    parameter int NUM_LOG   = 32,
    parameter int NUM_SPARE = 4,
    parameter int LW        = (NUM_LOG > 1) ? $clog2(NUM_LOG) : 1,
    parameter int PW        = $clog2(NUM_LOG + NUM_SPARE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [LW-1:0] req_lblk,
    output logic          rsp_valid,
    output logic          rsp_err,
    output logic [PW-1:0] rsp_pblk,
    output logic          busy,
    output logic          copy_req,
    output logic [PW-1:0] copy_src,
    output logic [PW-1:0] copy_dst,
    input  logic          copy_done,
    output logic          wlock
);
    import fbb_remap_pkg::*;

    localparam int SW = (NUM_SPARE > 1) ? $clog2(NUM_SPARE) : 1;
    localparam int CW = $clog2(NUM_SPARE + 1);
    localparam logic [PW-1:0] SPARE_BASE = PW'(NUM_LOG);
    localparam logic [LW:0]   LOG_LIMIT  = (LW+1)'(NUM_LOG);

    typedef struct packed {
        logic          rsp_valid;
        logic          rsp_err;
        logic [PW-1:0] rsp_pblk;
        logic          copying;
        logic [PW-1:0] src;
        logic [PW-1:0] dst;
        logic [LW-1:0] pend_lblk;
        logic [SW-1:0] pend_sidx;
    } state_t;

    state_t st_d, st_q;

    logic          look_hit;
    logic [SW-1:0] look_sidx;
    logic [SW-1:0] next_sidx;
    logic          exhausted;
    logic          commit;
    logic [PW-1:0] cur_phys;
    logic [PW-1:0] new_phys;
    logic          lblk_ok;
    op_e           op;

    assign commit = st_q.copying && copy_done;
    assign op     = op_e'(req_op);

    fbb_remap_table #(.NUM_LOG(NUM_LOG), .LW(LW), .SW(SW)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_idx  (req_lblk),
        .look_hit  (look_hit),
        .look_sidx (look_sidx),
        .wr_en     (commit),
        .wr_idx    (st_q.pend_lblk),
        .wr_sidx   (st_q.pend_sidx)
    );

    fbb_spare_alloc #(.NUM_SPARE(NUM_SPARE), .SW(SW), .CW(CW)) alloc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (commit),
        .next_sidx (next_sidx),
        .exhausted (exhausted)
    );

    assign lblk_ok  = ({1'b0, req_lblk} < LOG_LIMIT);
    assign cur_phys = look_hit ? (SPARE_BASE + PW'(look_sidx)) : PW'(req_lblk);
    assign new_phys = SPARE_BASE + PW'(next_sidx);

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        st_d.rsp_pblk  = '0;

        if (commit) st_d.copying = 1'b0;

        if (req_valid) begin
            st_d.rsp_valid = 1'b1;
            if (!lblk_ok) begin
                st_d.rsp_err = 1'b1;
            end else begin
                unique case (op)
                    OP_READ: st_d.rsp_pblk = cur_phys;
                    OP_PROG: begin
                        if (exhausted) st_d.rsp_err  = 1'b1;
                        else           st_d.rsp_pblk = cur_phys;
                    end
                    OP_FAIL: begin
                        if (st_q.copying || exhausted) begin
                            st_d.rsp_err = 1'b1;
                        end else begin
                            st_d.rsp_pblk  = new_phys;
                            st_d.copying   = 1'b1;
                            st_d.src       = cur_phys;
                            st_d.dst       = new_phys;
                            st_d.pend_lblk = req_lblk;
                            st_d.pend_sidx = next_sidx;
                        end
                    end
                    default: st_d.rsp_err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_pblk  = st_q.rsp_pblk;
    assign busy      = st_q.copying;
    assign copy_req  = st_q.copying;
    assign copy_src  = st_q.src;
    assign copy_dst  = st_q.dst;
    assign wlock     = exhausted;
endmodule

// File: rtl/fbb_remapper_chk.sv
module fbb_remapper_chk #(
    parameter int NUM_LOG   = 32,
    parameter int NUM_SPARE = 4,
    parameter int LW        = 5,
    parameter int PW        = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [LW-1:0] req_lblk,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [PW-1:0] rsp_pblk,
    input logic          busy,
    input logic          copy_req,
    input logic [PW-1:0] copy_src,
    input logic [PW-1:0] copy_dst,
    input logic          copy_done,
    input logic          wlock
);
    localparam logic [PW-1:0] BASE = PW'(NUM_LOG);
    localparam logic [PW:0]   TOP  = (PW+1)'(NUM_LOG + NUM_SPARE);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    copy_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && !copy_done) |=> (copy_req && $stable(copy_dst) && $stable(copy_src)));

    // R3
    copy_dst_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req |-> (copy_dst >= BASE && {1'b0, copy_dst} < TOP));

    // R6
    fail_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b10 && busy) |=> rsp_err);

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wlock |=> wlock);

    // R7
    prog_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b01 && wlock) |=> (rsp_err && rsp_pblk == '0));

    // R7
    no_copy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wlock && !copy_req) |=> !copy_req);
endmodule

bind fbb_remapper fbb_remapper_chk #(
    .NUM_LOG(NUM_LOG), .NUM_SPARE(NUM_SPARE), .LW(LW), .PW(PW)
) chk_i (.*);

// File: tb/fbb_remapper_tb_top.sv
`timescale 1ns/1ps
module fbb_remapper_tb_top;
    localparam int NL = 32;
    localparam int NS = 4;
    localparam int LW = 5;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [LW-1:0] req_lblk = '0;
    logic          rsp_valid, rsp_err, busy, copy_req, wlock;
    logic [PW-1:0] rsp_pblk, copy_src, copy_dst;
    logic          copy_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fbb_remapper #(.NUM_LOG(NL), .NUM_SPARE(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_lblk(req_lblk), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_pblk(rsp_pblk), .busy(busy), .copy_req(copy_req),
        .copy_src(copy_src), .copy_dst(copy_dst), .copy_done(copy_done),
        .wlock(wlock)
    );

    // op, lblk, expected err, expected pblk (no remaps present)
    localparam int NV = 7;
    localparam int V_OP  [NV] = '{0, 1, 0, 1, 3, 0, 3};
    localparam int V_LB  [NV] = '{0, 31, 17, 8, 4, 31, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 1, 0, 1};
    localparam int V_PB  [NV] = '{0, 31, 17, 8, 0, 31, 0};

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at negedge, response registered at next posedge, sample at negedge
    task automatic req(input int op, input int lb, input bit done_too = 1'b0);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 2'(op);
        req_lblk  = LW'(lb);
        copy_done = done_too;
        @(negedge clk);
        req_valid = 1'b0;
        copy_done = 1'b0;
    endtask

    task automatic finish_copy();
        @(negedge clk);
        copy_done = 1'b1;
        @(negedge clk);
        copy_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 copy_req", copy_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 wlock", wlock, 0);

        for (int i = 0; i < NV; i++) begin
            req(V_OP[i], V_LB[i]);
            chk(V_OP[i] == 3 ? "R9 err" : "R2 err", rsp_err, V_ERR[i]);
            chk(V_OP[i] == 3 ? "R9 pblk" : "R2 pblk", rsp_pblk, V_PB[i]);
            chk("R2 valid", rsp_valid, 1);
        end
        @(negedge clk);
        chk("R2 pulse ends", rsp_valid, 0);

        // first failure: lblk 5 -> spare 0 (pblk 32)
        req(2, 5);
        chk("R3 pblk", rsp_pblk, 32);
        chk("R3 err", rsp_err, 0);
        chk("R4 copy_req", copy_req, 1);
        chk("R4 busy", busy, 1);
        chk("R4 src", copy_src, 5);
        chk("R4 dst", copy_dst, 32);
        repeat (3) @(negedge clk);
        chk("R4 held", copy_req, 1);

        req(2, 6);
        chk("R6 err", rsp_err, 1);
        chk("R6 dst unchanged", copy_dst, 32);
        req(0, 5);
        chk("R5 before done", rsp_pblk, 5);

        // read together with copy_done: still old mapping
        req(0, 5, 1'b1);
        chk("R5 same edge", rsp_pblk, 5);
        chk("R4 released", copy_req, 0);
        req(0, 5);
        chk("R5 after done", rsp_pblk, 32);

        // re-fail the remapped block
        req(2, 5);
        chk("R10 pblk", rsp_pblk, 33);
        chk("R10 src", copy_src, 32);
        chk("R10 dst", copy_dst, 33);
        finish_copy();
        req(1, 5);
        chk("R10 prog", rsp_pblk, 33);

        req(2, 7);
        chk("R3 third", rsp_pblk, 34);
        finish_copy();
        req(2, 9);
        chk("R3 fourth", rsp_pblk, 35);
        chk("R7 not yet", wlock, 0);

        // program together with the last copy_done: still accepted
        req(1, 1, 1'b1);
        chk("R7 edge prog err", rsp_err, 0);
        chk("R7 edge prog pblk", rsp_pblk, 1);
        chk("R7 wlock", wlock, 1);

        req(1, 3);
        chk("R7 prog err", rsp_err, 1);
        chk("R7 prog pblk", rsp_pblk, 0);
        req(2, 4);
        chk("R7 fail err", rsp_err, 1);
        chk("R7 no copy", copy_req, 0);
        repeat (5) @(negedge clk);
        chk("R7 sticky", wlock, 1);

        req(0, 5);
        chk("R8 read 5", rsp_pblk, 33);
        chk("R8 err", rsp_err, 0);
        req(0, 9);
        chk("R8 read 9", rsp_pblk, 35);
        req(0, 7);
        chk("R8 read 7", rsp_pblk, 34);
        req(0, 2);
        chk("R8 read 2", rsp_pblk, 2);

        do_reset();
        chk("R1 wlock cleared", wlock, 0);
        req(0, 5);
        chk("R1 map cleared", rsp_pblk, 5);
        req(2, 12);
        chk("R3 restart at spare 0", rsp_pblk, 32);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule